// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between the program memory bus and the instruction decoder of a 16-bit processor. It keeps up to three prefetched program words: two queue stages and a side holding register. A word fetched from memory lands in the first stage and moves into the second stage on a later cycle. The decoder sees the word in the second stage. The holding register is used only when a word arrives while the first stage is occupied and cannot move forward.

Fetches go out only in cycles when the execution core leaves the memory bus free. At most one fetch is outstanding at a time, and the memory may answer after any latency of one cycle or more. The decoder takes the presented word with a one-cycle take strobe. On a change of program flow the core raises a flush together with a new target address. The flush empties the queue, discards the answer to any fetch that is still in flight, and fetching restarts at the target.

Top module: `prefetch_queue`

## Requirements
- R1: After reset the queue holds no word (`dec_valid` low) and `mem_addr` equals the `RESET_ADDR` parameter (default 0).
- R2: `mem_req` is high only in a cycle where `core_busy` is low, `flush` is low, no fetch is outstanding, and fewer than three words are held. A fetch stays outstanding from its request cycle until the cycle in which `mem_rvalid` is high.
- R3: `mem_addr` shows the address of the next fetch. It grows by 2 at the clock edge ending each request cycle that has no flush.
- R4: A word received into an empty queue is written into stage 1 at the edge ending its `mem_rvalid` cycle. It appears on `dec_word` with `dec_valid` high after the following edge.
- R5: While `dec_valid` is high and `dec_take` is low, `dec_word` holds its value. A `dec_take` while `dec_valid` is low changes nothing.
- R6: When the presented word is taken, the stage-1 word moves into stage 2 and the holding word moves into stage 1 at the same edge. A full queue with no refill therefore presents a new word on each of three consecutive cycles.
- R7: The holding register receives an incoming word only when stage 1 stays occupied, which happens when stage 2 is occupied and not taken. Words reach the decoder in fetch order, and the queue never holds more than three.
- R8: A `flush` empties the queue at the next edge, and `mem_addr` then equals the `flush_addr` sampled in the flush cycle.
- R9: The answer to a fetch that was outstanding when a flush occurred is discarded when it arrives and never reaches the decoder.
- R10: A flush takes priority over a same-cycle `dec_take` and over a same-cycle `mem_rvalid`. Neither of those adds a word after the flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_busy | input | 1 | The execution core uses the memory bus this cycle |
| flush | input | 1 | Change of flow: empty the queue and redirect fetching |
| flush_addr | input | 16 | Program address where fetching resumes after a flush |
| mem_req | output | 1 | Program fetch request this cycle |
| mem_addr | output | 16 | Address of the next program fetch |
| mem_rvalid | input | 1 | Answer to the outstanding fetch is on `mem_rdata` |
| mem_rdata | input | 16 | Fetched program word |
| dec_valid | output | 1 | Stage 2 holds a word for the decoder |
| dec_word | output | 16 | Word in stage 2 |
| dec_take | input | 1 | Decoder consumes the presented word |

## Verification
The assertions assume that the memory raises `mem_rvalid` exactly once for each request, and only after the request cycle. On that assumption the holding register can never overflow and the dropped-answer flag stays consistent. The bench memory model keeps a single pending request and answers it after a latency of one to three cycles. It never raises `mem_rvalid` on its own. Flushes, bus contention and decoder takes are drawn at random. This includes flushes in the same cycle as an answer or a take, and takes while nothing is presented.

// File: rtl/pq_pkg.sv
package pq_pkg;
    // Number of word slots and their fixed positions inside the slot vector.
    localparam int PQ_SLOTS = 3;
    localparam int PQ_OCC_W = $clog2(PQ_SLOTS + 1);
    localparam int SL_EXEC  = 0;   // stage 2, presented to the decoder
    localparam int SL_ENTRY = 1;   // stage 1, where fetched words land
    localparam int SL_HOLD  = 2;   // side buffer, used only when stage 1 is stuck

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,
        FS_WAIT = 2'd1,
        FS_DROP = 2'd2
    } fetch_state_e;
endpackage

// File: rtl/pq_fetch.sv
module pq_fetch #(
    parameter int ADDR_W     = 16,
    parameter int ADDR_STEP  = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    parameter int OCC_W      = pq_pkg::PQ_OCC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_busy,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              rvalid,
    input  logic [OCC_W-1:0]  occ,
    output logic              req,
    output logic [ADDR_W-1:0] addr,
    output logic              deliver
);
    import pq_pkg::*;

    localparam logic [OCC_W-1:0]  OCC_FULL = OCC_W'(PQ_SLOTS);
    localparam logic [ADDR_W-1:0] STEP_V   = ADDR_W'(ADDR_STEP);

    typedef struct packed {
        logic [ADDR_W-1:0] pc;
        fetch_state_e      st;
    } fstate_t;

    fstate_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        req     = !core_busy && !flush && (st_q.st == FS_IDLE) && (occ < OCC_FULL);
        deliver = rvalid && (st_q.st == FS_WAIT) && !flush;

        if (rvalid) begin
            st_d.st = FS_IDLE;
        end
        if (req) begin
            st_d.st = FS_WAIT;
            st_d.pc = st_q.pc + STEP_V;
        end
        if (flush) begin
            st_d.pc = flush_addr;
            st_d.st = (st_q.st != FS_IDLE && !rvalid) ? FS_DROP : FS_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pc <= RESET_ADDR;
            st_q.st <= FS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.pc;

    // R2
    bus_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> (!core_busy && !flush));
    // R2
    single_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !flush) |=> (addr == $past(addr) + STEP_V));
    // R8
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (addr == $past(flush_addr)));
    // R9
    stale_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && st_q.st == FS_WAIT && !rvalid) |=> !deliver);
endmodule

// File: rtl/pq_slots.sv
module pq_slots #(
    parameter int WORD_W = 16,
    parameter int OCC_W  = pq_pkg::PQ_OCC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              take,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              head_valid,
    output logic [WORD_W-1:0] head_word,
    output logic [OCC_W-1:0]  occ
);
    import pq_pkg::*;

    typedef struct packed {
        logic [PQ_SLOTS-1:0]             v;
        logic [PQ_SLOTS-1:0][WORD_W-1:0] w;
    } slots_t;

    slots_t sl_d, sl_q;
    logic   exec_free;

    always_comb begin
        sl_d      = sl_q;
        exec_free = !sl_q.v[SL_EXEC] || take;
        if (flush) begin
            sl_d.v = '0;
        end else begin
            if (exec_free) begin
                sl_d.v[SL_EXEC]  = sl_q.v[SL_ENTRY];
                sl_d.w[SL_EXEC]  = sl_q.w[SL_ENTRY];
                sl_d.v[SL_ENTRY] = sl_q.v[SL_HOLD];
                sl_d.w[SL_ENTRY] = sl_q.w[SL_HOLD];
                sl_d.v[SL_HOLD]  = 1'b0;
            end
            if (in_valid) begin
                if (!sl_d.v[SL_ENTRY]) begin
                    sl_d.v[SL_ENTRY] = 1'b1;
                    sl_d.w[SL_ENTRY] = in_word;
                end else begin
                    sl_d.v[SL_HOLD]  = 1'b1;
                    sl_d.w[SL_HOLD]  = in_word;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sl_q.v <= '0;
            sl_q.w <= '0;
        end else begin
            sl_q <= sl_d;
        end
    end

    assign head_valid = sl_q.v[SL_EXEC];
    assign head_word  = sl_q.w[SL_EXEC];
    assign occ        = OCC_W'($countones(sl_q.v));

    // R7
    hold_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sl_q.v[SL_HOLD] |-> (sl_q.v[SL_ENTRY] && sl_q.v[SL_EXEC]));
    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !(&sl_q.v));
    // R4
    entry_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sl_q.v[SL_ENTRY] && !sl_q.v[SL_EXEC] && !flush) |=> head_valid);
    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (head_valid && !take && !flush) |=> (head_valid && $stable(head_word)));
    // R8
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occ == '0));
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue #(
    parameter int ADDR_W    = 16,
    parameter int WORD_W    = 16,
    parameter int ADDR_STEP = 2,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_busy,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              dec_valid,
    output logic [WORD_W-1:0] dec_word,
    input  logic              dec_take
);
    import pq_pkg::*;

    logic [PQ_OCC_W-1:0] occ;
    logic                deliver;

    pq_fetch #(
        .ADDR_W     (ADDR_W),
        .ADDR_STEP  (ADDR_STEP),
        .RESET_ADDR (RESET_ADDR),
        .OCC_W      (PQ_OCC_W)
    ) fetch_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .core_busy  (core_busy),
        .flush      (flush),
        .flush_addr (flush_addr),
        .rvalid     (mem_rvalid),
        .occ        (occ),
        .req        (mem_req),
        .addr       (mem_addr),
        .deliver    (deliver)
    );

    pq_slots #(
        .WORD_W     (WORD_W),
        .OCC_W      (PQ_OCC_W)
    ) slots_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .take       (dec_take),
        .in_valid   (deliver),
        .in_word    (mem_rdata),
        .head_valid (dec_valid),
        .head_word  (dec_word),
        .occ        (occ)
    );
endmodule

// File: tb/prefetch_queue_tb_top.sv
module prefetch_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        core_busy = 1'b1;
    logic        flush = 1'b0;
    logic [15:0] flush_addr = '0;
    logic        mem_req;
    logic [15:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        dec_valid;
    logic [15:0] dec_word;
    logic        dec_take = 1'b0;

    always #5 clk = ~clk;

    prefetch_queue dut_i (
        .clk(clk), .rst_n(rst_n), .core_busy(core_busy), .flush(flush),
        .flush_addr(flush_addr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .dec_valid(dec_valid),
        .dec_word(dec_word), .dec_take(dec_take)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model: an ordered word list plus a flag for the presented head
    logic [15:0] mq[$];
    bit          head_rdy = 0;
    logic [15:0] m_pc = 16'h0000;
    bit          m_pend = 0;
    bit          m_drop = 0;

    // bench memory
    bit          mem_out = 0;
    logic [15:0] mem_a = '0;
    int          mem_cnt = 0;

    int    p_busy = 0, p_take = 0, p_flush = 0, lat_max = 1;
    string tag = "R1";
    string atag = "R3";

    function automatic logic [15:0] memval(logic [15:0] a);
        return {a[7:0], a[15:8]} ^ 16'h3C5A;
    endfunction

    task automatic chk(string t, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
        end
    endtask

    task automatic step();
        bit          b, tk, fl, rv, exp_req, dlv;
        logic [15:0] fa, rd;
        @(negedge clk);
        chk(tag, "dec_valid", 32'(dec_valid), 32'(head_rdy));
        if (head_rdy) chk(tag, "dec_word", 32'(dec_word), 32'(mq[0]));
        chk(atag, "mem_addr", 32'(mem_addr), 32'(m_pc));

        b  = ($urandom % 100) < p_busy;
        tk = ($urandom % 100) < p_take;
        fl = ($urandom % 100) < p_flush;
        fa = 16'($urandom) & 16'hFFFE;
        rv = 0;
        rd = '0;
        if (mem_out) begin
            if (mem_cnt <= 1) begin
                rv = 1;
                rd = memval(mem_a);
                mem_out = 0;
            end else begin
                mem_cnt--;
            end
        end
        core_busy  = b;
        dec_take   = tk;
        flush      = fl;
        flush_addr = fa;
        mem_rvalid = rv;
        mem_rdata  = rd;
        #1;
        exp_req = !b && !fl && !m_pend && (mq.size() < 3);
        chk("R2", "mem_req", 32'(mem_req), 32'(exp_req));
        if (mem_req) begin
            mem_out = 1;
            mem_a   = mem_addr;
            mem_cnt = 1 + int'($urandom % lat_max);
        end

        dlv = rv && m_pend && !m_drop && !fl;
        if (fl) begin
            mq.delete();
            head_rdy = 0;
            m_pc   = fa;
            m_drop = m_pend && !rv;
            m_pend = m_pend && !rv;
        end else begin
            if (head_rdy && tk) begin
                void'(mq.pop_front());
                head_rdy = 0;
            end
            if (!head_rdy && mq.size() > 0) head_rdy = 1;
            if (dlv) mq.push_back(rd);
            if (rv) begin
                m_pend = 0;
                m_drop = 0;
            end
            if (exp_req) begin
                m_pend = 1;
                m_pc   = m_pc + 16'd2;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1", "dec_valid after reset", 32'(dec_valid), 32'd0);
        chk("R1", "mem_addr after reset", 32'(mem_addr), 32'h0000);

        // R7: fill with an idle decoder, buffer takes the third word
        p_busy = 0; p_take = 0; p_flush = 0; lat_max = 1; tag = "R4 R7";
        for (int i = 0; i < 20; i++) step();
        chk("R7", "queue full presents first word", 32'(dec_word), 32'(memval(16'h0000)));

        // R6: drain a full queue with the bus blocked
        p_busy = 100; p_take = 100; tag = "R6";
        for (int i = 0; i < 6; i++) step();

        // R4 R5: random contention and decoder stalls
        p_busy = 40; p_take = 50; lat_max = 3; tag = "R4 R5";
        for (int i = 0; i < 1500; i++) step();

        // R8 R9 R10: random flushes
        p_busy = 30; p_take = 60; p_flush = 10; tag = "R8 R9 R10"; atag = "R3 R8";
        for (int i = 0; i < 1500; i++) step();
        p_busy = 10; p_take = 90; p_flush = 30;
        for (int i = 0; i < 500; i++) step();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule